// File: doc/BRIEF.md
# Flexible Multi-Timer Power Sequencer

This block orders the switching of a set of supply rails and auxiliary outputs: a parameterised number of regulator enables, three general-purpose output enables and a 32 kHz clock gate. Three independent sequencing timers each watch a selectable trigger: one of two external enable pins or a software bit held in the timer's own configuration register. Whenever a timer's trigger changes level, the timer walks through eight slot events, numbered 0 to 7 and spaced by a programmable period. The period is counted in ticks of a microsecond strobe.

Every output (a "slave") is bound to one of the three timers or to none. A bound slave switches on at its power-up slot when its timer runs upward. At its power-down slot on a downward run it does one of two things, chosen per timer: it sleeps (enable and low-power flag both cleared), or it holds its enable and raises its low-power flag. An unbound slave simply follows its own software bit. All settings arrive through a single-cycle register write port. A status output shows, per timer, whether a run is in progress and the current slot index.

Top module: `pwr_slot_sequencer`

## Requirements
- R1: After reset every slave enable, every low-power flag, every busy bit and every slot index is 0. Timers reset with trigger code 3 and slaves reset unbound with the software bit clear.
- R2: Timer m (m = 0, 1, 2) is configured at write address m. Its data bits are [1:0] trigger code, [4:2] period code, [5] inactive mode and [6] software trigger bit. Trigger codes: 0 selects pin en_pin[0], 1 selects en_pin[1], 2 selects the software bit, 3 selects nothing (the trigger is held low).
- R3: Each enable pin passes through two synchronizing flops. A pin change that is set up before clock edge k shows on seq_busy after edge k+2. A software trigger written at edge k shows on seq_busy after edge k+1.
- R4: The slot spacing is BASE_TICKS·2^code tick_us pulses, with the period code taken from data bits [4:2]. Slot 0 fires on the last tick of the first full period after the trigger change. Cycles without tick_us do not advance the count.
- R5: seq_busy[m] rises on a trigger change with seq_slot[3m+2:3m] at 0. The slot index advances by one per slot event. Busy falls after the slot-7 event.
- R6: Slave i is configured at write address 4+i. Its data bits are [1:0] binding (0 to 2 = timer, 3 = none), [4:2] power-up slot, [7:5] power-down slot and [8] software enable. Slave order on the outputs: bits 0 to N_REG-1 are the regulators, the next three bits are the GPIO enables, and the top bit is the 32 kHz clock gate.
- R7: A bound slave whose timer fires its power-up slot while running upward sets its enable and clears its low-power flag on the following clock edge.
- R8: On a downward run with inactive mode 0, a bound slave's power-down slot clears its enable and its low-power flag on the following edge.
- R9: On a downward run with inactive mode 1, a bound slave's power-down slot sets its low-power flag and leaves its enable unchanged.
- R10: An unbound slave drives its enable from its software bit, one edge after the configuration write, with the low-power flag 0.
- R11: A trigger reversal during a run restarts the timer at slot 0 in the new direction with a fresh period count. Slaves keep their state until their own slot for the new direction fires.
- R12: A write to address 3, or to any address beyond the last slave, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle microsecond strobe |
| en_pin | input | 2 | Asynchronous hardware enable pins |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | AW | Configuration register address |
| wr_data | input | 9 | Configuration write data |
| slv_en | output | N_REG+4 | Slave enables |
| slv_lp | output | N_REG+4 | Slave low-power flags |
| seq_busy | output | 3 | Per-timer run in progress |
| seq_slot | output | 9 | Per-timer slot index, 3 bits each |

## Verification
Each result has a fixed latency. A pin change reaches seq_busy three edges after it is applied. A software trigger or configuration write takes effect one edge after the write edge. A slave reacts one edge after the cycle in which its slot event fires. A behavioural reference model in the bench advances on every rising edge using these latencies. Its outputs are compared with the design's outputs at every falling edge, so the check for each stimulus falls in the cycle where the result is due. Directed checks confirm the pin latency, the unbound-slave latency and the end-of-run busy drop, using counts worked out from the requirements.

// File: rtl/pwr_slot_sequencer.sv
module pwr_slot_sequencer #(
  parameter int N_REG      = 6,
  parameter int BASE_TICKS = 40,
  parameter int AW         = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_us,
  input  logic [1:0]           en_pin,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [8:0]           wr_data,
  output logic [N_REG+3:0]     slv_en,
  output logic [N_REG+3:0]     slv_lp,
  output logic [2:0]           seq_busy,
  output logic [8:0]           seq_slot
);
  localparam int NM    = 3;
  localparam int N_SLV = N_REG + 4;
  localparam int PW    = $clog2(BASE_TICKS * 128 + 1);
  localparam int SBASE = 4;

  logic [1:0] sync1, sync2;

  logic [1:0]    m_trig [NM];
  logic [2:0]    m_per  [NM];
  logic [NM-1:0] m_inact, m_sw;

  logic [1:0] s_src [N_SLV];
  logic [2:0] s_up  [N_SLV];
  logic [2:0] s_dn  [N_SLV];
  logic [N_SLV-1:0] s_sw;

  logic [NM-1:0] trig_now, trig_q, run, dir, fire, flip;
  logic [PW-1:0] pre  [NM];
  logic [2:0]    slot [NM];

  logic [3:0] fire4, dir4, inact4;
  logic [2:0] slot_p [4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= en_pin;
      sync2 <= sync1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < NM; k++) begin
        m_trig[k] <= 2'd3;
        m_per[k]  <= '0;
      end
      m_inact <= '0;
      m_sw    <= '0;
      for (int k = 0; k < N_SLV; k++) begin
        s_src[k] <= 2'd3;
        s_up[k]  <= '0;
        s_dn[k]  <= '0;
      end
      s_sw <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NM; k++)
        if (wr_addr == AW'(k)) begin
          m_trig[k]  <= wr_data[1:0];
          m_per[k]   <= wr_data[4:2];
          m_inact[k] <= wr_data[5];
          m_sw[k]    <= wr_data[6];
        end
      for (int k = 0; k < N_SLV; k++)
        if (wr_addr == AW'(k + SBASE)) begin
          s_src[k] <= wr_data[1:0];
          s_up[k]  <= wr_data[4:2];
          s_dn[k]  <= wr_data[7:5];
          s_sw[k]  <= wr_data[8];
        end
    end

  for (genvar m = 0; m < NM; m++) begin : g_master
    logic [PW-1:0] lim;

    always_comb
      case (m_trig[m])
        2'd0:    trig_now[m] = sync2[0];
        2'd1:    trig_now[m] = sync2[1];
        2'd2:    trig_now[m] = m_sw[m];
        default: trig_now[m] = 1'b0;
      endcase

    assign lim     = PW'(BASE_TICKS) << m_per[m];
    assign flip[m] = trig_now[m] != trig_q[m];
    assign fire[m] = run[m] & tick_us & (pre[m] == lim - 1'b1) & ~flip[m];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        trig_q[m] <= 1'b0;
        run[m]    <= 1'b0;
        dir[m]    <= 1'b0;
        pre[m]    <= '0;
        slot[m]   <= '0;
      end else if (flip[m]) begin
        trig_q[m] <= trig_now[m];
        run[m]    <= 1'b1;
        dir[m]    <= trig_now[m];
        pre[m]    <= '0;
        slot[m]   <= '0;
      end else if (fire[m]) begin
        pre[m] <= '0;
        if (slot[m] == 3'd7) run[m] <= 1'b0;
        else                 slot[m] <= slot[m] + 3'd1;
      end else if (run[m] && tick_us) begin
        pre[m] <= pre[m] + 1'b1;
      end

    assign seq_slot[3*m +: 3] = slot[m];
    assign slot_p[m]          = slot[m];
  end

  assign slot_p[3] = 3'd0;
  assign fire4     = {1'b0, fire};
  assign dir4      = {1'b0, dir};
  assign inact4    = {1'b0, m_inact};
  assign seq_busy  = run;

  for (genvar i = 0; i < N_SLV; i++) begin : g_slave
    logic [1:0] sel;
    assign sel = s_src[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        slv_en[i] <= 1'b0;
        slv_lp[i] <= 1'b0;
      end else if (sel == 2'd3) begin
        slv_en[i] <= s_sw[i];
        slv_lp[i] <= 1'b0;
      end else if (fire4[sel]) begin
        if (dir4[sel] && slot_p[sel] == s_up[i]) begin
          slv_en[i] <= 1'b1;
          slv_lp[i] <= 1'b0;
        end else if (!dir4[sel] && slot_p[sel] == s_dn[i]) begin
          if (inact4[sel]) slv_lp[i] <= 1'b1;
          else begin
            slv_en[i] <= 1'b0;
            slv_lp[i] <= 1'b0;
          end
        end
      end
  end
endmodule

// File: rtl/pwr_slot_sequencer_chk.sv
module pwr_slot_sequencer_chk #(
  parameter int N_SLV = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       busy,
  input logic [8:0]       slot,
  input logic [2:0]       fire,
  input logic [N_SLV-1:0] en,
  input logic [N_SLV-1:0] lp
);
  for (genvar m = 0; m < 3; m++) begin : g_m
    assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[m]) |-> ($past(slot[3*m +: 3]) == 3'd7 && $past(fire[m])));

    assert_start_slot0_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[m]) |-> slot[3*m +: 3] == 3'd0);

    assert_slot_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[m] && $past(busy[m])) |->
        (slot[3*m +: 3] == $past(slot[3*m +: 3]) ||
         slot[3*m +: 3] == $past(slot[3*m +: 3]) + 3'd1 ||
         slot[3*m +: 3] == 3'd0));
  end

  for (genvar i = 0; i < N_SLV; i++) begin : g_s
    assert_lp_on_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lp[i]) |-> $past(|fire));

    assert_sleep_clears_lp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en[i]) |-> !lp[i]);
  end
endmodule

bind pwr_slot_sequencer pwr_slot_sequencer_chk #(.N_SLV(N_SLV)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(seq_busy), .slot(seq_slot),
  .fire(fire), .en(slv_en), .lp(slv_lp)
);

// File: tb/pwr_slot_sequencer_tb_top.sv
module pwr_slot_sequencer_tb_top;
  localparam int NR = 2;
  localparam int NS = NR + 4;
  localparam int BT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_us = 1'b1;
  logic [1:0]    en_pin = '0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [8:0]    wr_data = '0;
  logic [NS-1:0] slv_en, slv_lp;
  logic [2:0]    seq_busy;
  logic [8:0]    seq_slot;

  int checks = 0, errors = 0, cyc = 0, tick_mode = 0, tcnt = 0;
  string req = "R1";
  bit cmp_on = 0, done = 0;

  always #2.5 clk = ~clk;

  pwr_slot_sequencer #(.N_REG(NR), .BASE_TICKS(BT), .AW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .en_pin(en_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .slv_en(slv_en), .slv_lp(slv_lp), .seq_busy(seq_busy), .seq_slot(seq_slot)
  );

  // behavioural reference model
  int s1[2], s2[2];
  int mt[3], mp[3], mi[3], ms[3];
  int ss[NS], su[NS], sd[NS], sw[NS];
  int tq[3], rn[3], dr[3], pr[3], sl[3];
  int en[NS], lp[NS];

  always @(posedge clk) begin
    int tr, m;
    int f[3], fs[3], fd[3];
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin s1[k] = 0; s2[k] = 0; end
      for (int k = 0; k < 3; k++) begin
        mt[k] = 3; mp[k] = 0; mi[k] = 0; ms[k] = 0;
        tq[k] = 0; rn[k] = 0; dr[k] = 0; pr[k] = 0; sl[k] = 0;
      end
      for (int k = 0; k < NS; k++) begin
        ss[k] = 3; su[k] = 0; sd[k] = 0; sw[k] = 0; en[k] = 0; lp[k] = 0;
      end
    end else begin
      for (int k = 0; k < 3; k++) begin
        tr = (mt[k] == 0) ? s2[0] : (mt[k] == 1) ? s2[1] : (mt[k] == 2) ? ms[k] : 0;
        f[k] = 0; fs[k] = 0; fd[k] = 0;
        if (tr != tq[k]) begin
          tq[k] = tr; rn[k] = 1; dr[k] = tr; pr[k] = 0; sl[k] = 0;
        end else if (rn[k] == 1 && tick_us) begin
          if (pr[k] == BT * (1 << mp[k]) - 1) begin
            f[k] = 1; fs[k] = sl[k]; fd[k] = dr[k]; pr[k] = 0;
            if (sl[k] == 7) rn[k] = 0; else sl[k] = sl[k] + 1;
          end else pr[k] = pr[k] + 1;
        end
      end
      for (int i = 0; i < NS; i++) begin
        if (ss[i] == 3) begin
          en[i] = sw[i]; lp[i] = 0;
        end else begin
          m = ss[i];
          if (f[m] == 1) begin
            if (fd[m] == 1 && fs[m] == su[i]) begin en[i] = 1; lp[i] = 0; end
            else if (fd[m] == 0 && fs[m] == sd[i]) begin
              if (mi[m] == 1) lp[i] = 1;
              else begin en[i] = 0; lp[i] = 0; end
            end
          end
        end
      end
      for (int k = 0; k < 2; k++) begin s2[k] = s1[k]; s1[k] = int'(en_pin[k]); end
      if (wr_en) begin
        if (wr_addr < 3) begin
          mt[wr_addr] = wr_data[1:0]; mp[wr_addr] = wr_data[4:2];
          mi[wr_addr] = wr_data[5];   ms[wr_addr] = wr_data[6];
        end else if (wr_addr >= 4 && wr_addr < 4 + NS) begin
          ss[wr_addr-4] = wr_data[1:0]; su[wr_addr-4] = wr_data[4:2];
          sd[wr_addr-4] = wr_data[7:5]; sw[wr_addr-4] = wr_data[8];
        end
      end
    end
    cmp_on = 1;
  end

  always @(negedge clk) begin
    logic [NS-1:0] xe, xl;
    logic [2:0] xb;
    logic [8:0] xs;
    if (cmp_on && !done) begin
      for (int i = 0; i < NS; i++) begin xe[i] = en[i][0]; xl[i] = lp[i][0]; end
      for (int k = 0; k < 3; k++) begin xb[k] = rn[k][0]; xs[3*k +: 3] = sl[k][2:0]; end
      checks++;
      if (slv_en !== xe || slv_lp !== xl || seq_busy !== xb || seq_slot !== xs) begin
        errors++;
        $display("FAIL %s cycle %0d: en=%b lp=%b busy=%b slot=%h expected en=%b lp=%b busy=%b slot=%h",
                 req, cyc, slv_en, slv_lp, seq_busy, seq_slot, xe, xl, xb, xs);
      end
    end
    tcnt++;
    tick_us <= (tick_mode == 0) ? 1'b1 : (tcnt % 3 == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected finish earlier", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [8:0] mc(int trig, int per, int inact, int swb);
    return {2'b00, 1'(swb), 1'(inact), 3'(per), 2'(trig)};
  endfunction

  function automatic logic [8:0] sc(int src, int up, int dn, int swb);
    return {1'(swb), 3'(dn), 3'(up), 2'(src)};
  endfunction

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    req = "R1";
    chk("R1 enables", 16'(slv_en), 16'h0);
    chk("R1 lp", 16'(slv_lp), 16'h0);
    chk("R1 busy", 16'(seq_busy), 16'h0);

    req = "R2";
    wr(0, mc(0, 0, 0, 0));
    wr(1, mc(1, 1, 1, 0));
    wr(2, mc(2, 2, 0, 0));
    req = "R6";
    wr(4, sc(0, 1, 6, 0));
    wr(5, sc(0, 7, 0, 0));
    wr(6, sc(1, 0, 3, 0));
    wr(7, sc(2, 3, 3, 0));
    wr(8, sc(3, 0, 0, 1));
    wr(9, sc(1, 2, 2, 0));
    idle(1);
    chk("R10 sw slave on", 16'(slv_en[4]), 16'h1);

    req = "R12";
    wr(3, 9'h1ff);
    wr(15, 9'h1ff);
    idle(2);
    chk("R12 no effect", 16'(slv_en), 16'h10);

    req = "R3";
    @(negedge clk);
    en_pin[0] = 1'b1;
    idle(2);
    chk("R3 busy before sync", 16'(seq_busy[0]), 16'h0);
    idle(1);
    chk("R3 busy after sync", 16'(seq_busy[0]), 16'h1);

    req = "R7";
    idle(30);
    chk("R5 busy ends", 16'(seq_busy[0]), 16'h0);
    chk("R7 slaves up", 16'(slv_en[1:0]), 16'h3);

    req = "R8";
    en_pin[0] = 1'b0;
    idle(30);
    chk("R8 sleep", 16'(slv_en[1:0]), 16'h0);

    req = "R4";
    tick_mode = 1;
    en_pin[1] = 1'b1;
    idle(120);
    req = "R9";
    en_pin[1] = 1'b0;
    idle(120);
    chk("R9 lp kept en", 16'({slv_en[5], slv_en[2], slv_lp[5], slv_lp[2]}), 16'hf);
    tick_mode = 0;

    req = "R5";
    wr(2, mc(2, 2, 0, 1));
    idle(80);
    wr(2, mc(2, 2, 0, 0));
    idle(80);

    req = "R11";
    en_pin[0] = 1'b1;
    idle(8);
    en_pin[0] = 1'b0;
    idle(5);
    en_pin[0] = 1'b1;
    idle(12);
    en_pin[0] = 1'b0;
    idle(40);

    req = "R4";
    wr(0, mc(0, 3, 0, 0));
    en_pin[0] = 1'b1;
    idle(150);
    en_pin[0] = 1'b0;
    idle(150);

    req = "R10";
    wr(8, sc(3, 0, 0, 0));
    idle(1);
    chk("R10 sw slave off", 16'(slv_en[4]), 16'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule